// File: doc/BRIEF.md
# UART Auto-Baud Sync Detector

This block learns the bit rate of a host talking over a serial debug line. Instead of relying on a fixed divider, it waits for one known synchronization byte and measures it. The byte is 0x80, sent as an 8N1 frame. The line idles high, each frame opens with a low start bit, carries eight data bits least significant first, and closes with a high stop bit. With 0x80 the start bit and the seven zero data bits form a single low stretch of eight bit periods, which ends when the high bit 7 arrives. The block counts the system clock cycles of that low stretch and divides by eight with rounding. The result is the bit period in clock cycles, which the UART timing logic downstream uses as its divider.

The raw line first passes through a two-flop synchronizer and then an edge detector. A counter starts on the falling edge and stops on the next rising edge. Once a valid period has been found, the block raises a locked flag and ignores all later traffic until reset. If the low stretch is too long for the counter, the block reports a zero period with lock low and re-arms. All logic is cleared by an asynchronous active-high reset and advances only while the enable input is high.

Top module: `autobaud_sync_det`

## Requirements
- R1: After reset, period_o is 0 and locked_o is 0.
- R2: When serial_in is low for L consecutive sampling edges and then returns high, the block locks with period_o = (L + 4) >> 3, which is L/8 rounded to nearest. This holds when L is at least 4 and at most LOW_MAX = 2^(CNT_W+3) - 5.
- R3: For a host bit period of P cycles, a low stretch of 8P-1, 8P or 8P+1 cycles gives period_o = P. This tolerates one cycle of skew on each edge.
- R4: Suppose the first edge that samples serial_in high after the low stretch is edge n. Then locked_o and period_o are still unchanged after edge n+1 and are updated after edge n+2. This is well inside the ten-cycle gap the host leaves after the frame.
- R5: Once locked_o is 1, it stays 1 and period_o does not change until reset, whatever serial_in does.
- R6: If serial_in stays low for more than LOW_MAX sampling edges, period_o stays 0 and locked_o stays 0. After the line returns high the block re-arms, and a later valid low stretch locks normally.
- R7: A low pulse of 1 to 3 cycles does not lock the block, and the block stays armed for the next sync frame.
- R8: While en is 0, nothing changes, including the synchronizer. A frame sent while en is 0 does not lock the block.
- R9: When locked_o is 1, period_o is nonzero. When locked_o is 0, period_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Debug enable; the logic advances only while it is high |
| serial_in | input | 1 | Raw serial line from the host, idles high |
| period_o | output | CNT_W | Measured bit period in clock cycles, 0 when not locked |
| locked_o | output | 1 | High once a valid sync frame has been measured |

## Verification
The main check sweeps every bit period from 1 to 63 cycles in a 6-bit configuration. Each period is tried with the low stretch one cycle short, exact and one cycle long. This separates correct rounding from plain truncation or an off-by-one count. A dense sweep over short stretches tests the arithmetic near each rounding boundary. Runs of 507 and 508 cycles separate the last valid count from overflow. Pulses of 1 to 3 cycles, traffic sent after lock, and frames sent while enable is low show that the arming, holding and freezing rules are kept apart.

// File: rtl/abd_pkg.sv
package abd_pkg;
  // Low stretch of the sync byte spans 2**SYNC_SHIFT bit periods
  localparam int unsigned SYNC_SHIFT = 3;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_LOW    = 2'd1,
    ST_LOCKED = 2'd2,
    ST_HUNT   = 2'd3
  } abd_state_e;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sr <= {STAGES{RESET_VAL}};
    end else if (en) begin
      sr <= {sr[STAGES-2:0], d};
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/abd_edge.sv
module abd_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic fall,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev <= 1'b1;
    end else if (en) begin
      prev <= d;
    end
  end

  assign fall = prev & ~d;
  assign rise = ~prev & d;
endmodule

// File: rtl/abd_lowcnt.sv
module abd_lowcnt #(
  parameter int unsigned    W     = 19,
  parameter logic [W-1:0]   LIMIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         full
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      if (start) begin
        cnt <= W'(1);
      end else if (inc && !full) begin
        cnt <= cnt + W'(1);
      end
    end
  end

  assign full = (cnt == LIMIT);
endmodule

// File: rtl/abd_round.sv
module abd_round #(
  parameter int unsigned IN_W  = 19,
  parameter int unsigned SHIFT = 3,
  localparam int unsigned OUT_W = IN_W - SHIFT
) (
  input  logic [IN_W-1:0]  len,
  output logic [OUT_W-1:0] q,
  output logic             zero
);
  localparam logic [IN_W-1:0] HALF = IN_W'(1) << (SHIFT - 1);

  logic [IN_W-1:0] sum;

  // Caller keeps len at or below all-ones minus HALF, so no carry is lost
  assign sum  = len + HALF;
  assign q    = sum[IN_W-1:SHIFT];
  assign zero = (q == '0);
endmodule

// File: rtl/autobaud_sync_det.sv
module autobaud_sync_det #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             serial_in,
  output logic [CNT_W-1:0] period_o,
  output logic             locked_o
);
  import abd_pkg::*;

  localparam int unsigned   LOW_W   = CNT_W + SYNC_SHIFT;
  localparam logic [LOW_W-1:0] HALF = LOW_W'(1) << (SYNC_SHIFT - 1);
  localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}} - HALF;

  abd_state_e        state;
  logic              line_s;
  logic              fall;
  logic              rise;
  logic              start;
  logic              inc;
  logic              full;
  logic [LOW_W-1:0]  low_len;
  logic [CNT_W-1:0]  rounded;
  logic              rounded_zero;

  abd_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (serial_in),
    .q   (line_s)
  );

  abd_edge edge_i (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .d    (line_s),
    .fall (fall),
    .rise (rise)
  );

  assign start = (state == ST_ARMED) && fall;
  assign inc   = (state == ST_LOW) && !line_s;

  abd_lowcnt #(
    .W     (LOW_W),
    .LIMIT (LOW_MAX)
  ) cnt_i (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .start (start),
    .inc   (inc),
    .cnt   (low_len),
    .full  (full)
  );

  abd_round #(
    .IN_W  (LOW_W),
    .SHIFT (SYNC_SHIFT)
  ) round_i (
    .len  (low_len),
    .q    (rounded),
    .zero (rounded_zero)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state    <= ST_ARMED;
      period_o <= '0;
      locked_o <= 1'b0;
    end else if (en) begin
      case (state)
        ST_ARMED: begin
          if (fall) begin
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (rise) begin
            if (rounded_zero) begin
              state <= ST_ARMED;
            end else begin
              state    <= ST_LOCKED;
              period_o <= rounded;
              locked_o <= 1'b1;
            end
          end else if (full) begin
            state <= ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (line_s) begin
            state <= ST_ARMED;
          end
        end
        default: begin
          state <= ST_LOCKED;
        end
      endcase
    end
  end
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             serial_in,
  input logic [CNT_W-1:0] period_o,
  input logic             locked_o
);
  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o);

  // R5
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> $stable(period_o));

  // R9
  lock_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> (period_o != '0));

  // R9
  unlocked_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !locked_o |-> (period_o == '0));

  // R8
  disabled_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(period_o) && $stable(locked_o)));

  // R4
  lock_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked_o) && $past(en)) |-> $past(serial_in));
endmodule

bind autobaud_sync_det abd_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .serial_in (serial_in),
  .period_o  (period_o),
  .locked_o  (locked_o)
);

// File: tb/autobaud_sync_det_tb_top.sv
module autobaud_sync_det_tb_top;
  localparam int unsigned CNT_W   = 6;
  localparam int          LOW_MAX = (1 << (CNT_W + 3)) - 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b1;
  logic             serial_in = 1'b1;
  logic [CNT_W-1:0] period_o;
  logic             locked_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  autobaud_sync_det #(.CNT_W(CNT_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .serial_in (serial_in),
    .period_o  (period_o),
    .locked_o  (locked_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst       = 1'b1;
    en        = 1'b1;
    serial_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Line low for exactly len sampling edges, then high (bit 7 and stop bit follow as idle high)
  task automatic send_low(input int len);
    @(negedge clk);
    serial_in = 1'b0;
    repeat (len) @(posedge clk);
    @(negedge clk);
    serial_in = 1'b1;
  endtask

  // After send_low: the first high sample is the next edge n; outputs move after n+2
  task automatic expect_lock(input string req, input int exp_period);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({req, " R4 lock not before n+2"}, int'(locked_o), 0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R4 lock at n+2"}, int'(locked_o), 1);
    chk({req, " period"}, int'(period_o), exp_period);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 period", int'(period_o), 0);
    chk("R1 locked", int'(locked_o), 0);

    // R3 every bit period with -1/0/+1 skew
    for (int p = 1; p < 64; p++) begin
      for (int j = -1; j <= 1; j++) begin
        do_reset();
        send_low(8 * p + j);
        expect_lock("R3", p);
      end
    end

    // R2 dense sweep of short stretches against rounded L/8
    for (int len = 4; len <= 44; len++) begin
      do_reset();
      send_low(len);
      expect_lock("R2", (len + 4) / 8);
    end

    // R2 largest legal stretch
    do_reset();
    send_low(LOW_MAX);
    expect_lock("R2 max", (LOW_MAX + 4) / 8);

    // R7 short pulses ignored, block stays armed
    do_reset();
    for (int g = 1; g <= 3; g++) begin
      send_low(g);
      settle(6);
      chk("R7 glitch no lock", int'(locked_o), 0);
      chk("R7 glitch period", int'(period_o), 0);
    end
    send_low(24);
    expect_lock("R7 after glitches", 3);

    // R5 traffic after lock ignored
    send_low(100);
    settle(6);
    chk("R5 period held", int'(period_o), 3);
    chk("R5 lock held", int'(locked_o), 1);
    send_low(2);
    settle(6);
    chk("R5 period held after pulse", int'(period_o), 3);

    // R6 overflow then re-arm
    do_reset();
    send_low(LOW_MAX + 1);
    settle(6);
    chk("R6 overflow lock", int'(locked_o), 0);
    chk("R6 overflow period", int'(period_o), 0);
    send_low(16);
    expect_lock("R6 rearm", 2);

    // R8 frame while disabled is not seen
    do_reset();
    @(negedge clk);
    en = 1'b0;
    send_low(40);
    settle(6);
    chk("R8 disabled lock", int'(locked_o), 0);
    chk("R8 disabled period", int'(period_o), 0);
    @(negedge clk);
    en = 1'b1;
    settle(4);
    send_low(40);
    expect_lock("R8 enabled", 5);
    // R9 consistency at the ports
    chk("R9 locked nonzero", int'(period_o != 0), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule